// File: doc/BRIEF.md
# Pointer-Latched ROM Bank Controller

This block sits on the cartridge side of an 8-bit console with a 13-bit address bus and selects which part of a 64 KB ROM answers each access. The ROM is split into two 32 KB sections. Each section holds eight 4 KB banks. The controller watches every valid bus cycle, including the data bus, and changes bank state on specific address and data patterns. The CPU never writes to a bank register directly.

The cartridge window is split in two. The top 1 KB of the window is the code area, and its bank comes from a primary register. The lower 3 KB is the data area, and its bank comes from a temporary register. Every access to the code area copies the primary bank into the temporary register. Reading a zero-page pointer copies the pointer's normally unused top bits into the temporary register. As a result, an indirect load through that pointer reaches the bank the pointer names, and no explicit switch is needed. Two hotspot patterns in the low address space allow explicit switching: one takes effect at once, and the other is deferred until the next code-area access.

Top module: `ptr_bank_ctrl`

## Requirements
- R1: While reset is active, the section bit, the primary bank and the temporary bank are all 0. The first accesses after reset therefore map to section 0, bank 0.
- R2: The ROM address is formed as {section, bank[2:0], A[11:0]}. The chip enable equals A12. Whenever A12 is 0, the bank field shows the temporary bank.
- R3: An access with A12..A10 = 111 is served from the primary bank in the same cycle. On a valid cycle it also copies the primary bank into the temporary bank.
- R4: An access with A12 = 1 and A11..A10 not both 1 is served from the temporary bank. The primary bank has no effect on it.
- R5: A valid cycle with A12..A10 = 011 and A3 = 1 makes the following changes at once: the section bit takes A7, and both the primary and temporary banks take A6..A4.
- R6: A valid cycle with A12..A10 = 001 and A3 = 1 loads only the primary bank, with A6..A4. Accesses in the lower 3 KB keep the old temporary bank until the next access to the top 1 KB.
- R7: While the primary bank is 0 to 3, a valid cycle with the address in $0080–$00BF loads the temporary bank with D7..D5.
- R8: While the primary bank is 4 to 7, an access in $0080–$00BF leaves the temporary bank unchanged.
- R9: A cycle with the valid strobe low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cyc_valid | input | 1 | Marks a valid bus cycle; state updates only on these cycles |
| bus_addr | input | 13 | CPU address bus A12..A0 |
| bus_data | input | 8 | CPU data bus, snooped |
| rom_addr | output | 16 | ROM address {section, bank, A11..A0} |
| rom_ce | output | 1 | ROM chip enable, high for cartridge accesses |

## Verification
The ROM address and enable are combinational functions of the current address and the stored state, so they are due in the same cycle as the address that produces them. A bank change caused by a cycle appears only from the next cycle on. The bench drives each cycle on the falling clock edge and compares the outputs two nanoseconds later, before the rising edge. It then advances its behavioural model at that rising edge, so every delayed effect is checked on the cycle that follows its cause.

// File: rtl/ptr_bank_ctrl.sv
module ptr_bank_ctrl #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic [15:0]   rom_addr,
  output logic          rom_ce
);
  localparam int OFS = AW - 1;

  logic          sect_q;
  logic [BW-1:0] prim_q;
  logic [BW-1:0] temp_q;

  logic code_win, hot_now, hot_late, zp_ptr;
  logic [BW-1:0] bank_sel;

  assign code_win = bus_addr[12:10] == 3'b111;
  assign hot_now  = bus_addr[12:10] == 3'b011 && bus_addr[3];
  assign hot_late = bus_addr[12:10] == 3'b001 && bus_addr[3];
  assign zp_ptr   = bus_addr[12:6] == 7'b0000010 && !prim_q[2];

  assign bank_sel = code_win ? prim_q : temp_q;
  assign rom_addr = {sect_q, bank_sel, bus_addr[OFS-1:0]};
  assign rom_ce   = bus_addr[12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= 1'b0;
      prim_q <= '0;
      temp_q <= '0;
    end else if (cyc_valid) begin
      if (hot_now) begin
        sect_q <= bus_addr[7];
        prim_q <= bus_addr[6:4];
        temp_q <= bus_addr[6:4];
      end else begin
        if (hot_late) prim_q <= bus_addr[6:4];
        if (code_win) temp_q <= prim_q;
        else if (zp_ptr) temp_q <= bus_data[DW-1:DW-BW];
      end
    end
  end

  p_code_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_addr[12:10] == 3'b111 |=> rom_addr[14:12] == $past(rom_addr[14:12]) || !bus_addr[12]);
  p_hot_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_addr[12:10] == 3'b011 && bus_addr[3] |=> sect_q == $past(bus_addr[7]) && prim_q == $past(bus_addr[6:4]) && temp_q == $past(bus_addr[6:4]));
  p_hot_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_addr[12:10] == 3'b001 && bus_addr[3] |=> prim_q == $past(bus_addr[6:4]) && $stable(temp_q) && $stable(sect_q));
  p_ptr_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_addr >= 13'h0080 && bus_addr <= 13'h00BF && prim_q < 3'd4 |=> temp_q == $past(bus_data[7:5]));
  p_ptr_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_addr >= 13'h0080 && bus_addr <= 13'h00BF && prim_q >= 3'd4 |=> $stable(temp_q) && $stable(prim_q));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> $stable(sect_q) && $stable(prim_q) && $stable(temp_q));
  p_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[12] |-> !rom_ce && rom_addr[14:12] == temp_q);
endmodule

// File: tb/ptr_bank_ctrl_bench.sv
module ptr_bank_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_valid = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0] bus_data = '0;
  logic [15:0] rom_addr;
  logic rom_ce;

  int vecs = 0;
  int errs = 0;
  int m_sec = 0, m_pri = 0, m_tmp = 0;

  ptr_bank_ctrl u_ptr_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .rom_addr(rom_addr), .rom_ce(rom_ce)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  task automatic step(input logic [12:0] a, input logic [7:0] d, input logic v, input string req);
    int bank;
    logic [15:0] exp_a;
    @(negedge clk);
    bus_addr = a; bus_data = d; cyc_valid = v;
    #2;
    bank = (a[12:10] == 3'b111) ? m_pri : m_tmp;
    exp_a = {m_sec[0], bank[2:0], a[11:0]};
    vecs++;
    if (rom_addr !== exp_a || rom_ce !== a[12]) begin
      errs++;
      $display("FAIL %s: addr=%h got rom_addr=%h ce=%b expected rom_addr=%h ce=%b",
               req, a, rom_addr, rom_ce, exp_a, a[12]);
    end
    @(posedge clk);
    if (v && rst_n) begin
      if (a[12:10] == 3'b011 && a[3]) begin
        m_sec = a[7]; m_pri = a[6:4]; m_tmp = a[6:4];
      end else begin
        if (a[12:10] == 3'b001 && a[3]) m_pri = a[6:4];
        if (a[12:10] == 3'b111) m_tmp = m_pri;
        else if (a >= 13'h0080 && a <= 13'h00BF && m_pri < 4) m_tmp = d[7:5];
      end
    end
  endtask

  initial begin
    step(13'h1234, 8'h00, 1'b1, "R1");
    step(13'h0FBF, 8'h00, 1'b1, "R1");
    step(13'h1C55, 8'h00, 1'b1, "R1");
    rst_n = 1'b1;
    step(13'h1100, 8'h00, 1'b1, "R1");
    step(13'h1C10, 8'h00, 1'b1, "R3");
    step(13'h0FBF, 8'h00, 1'b1, "R5");
    step(13'h1000, 8'h00, 1'b1, "R5");
    step(13'h0500, 8'h00, 1'b1, "R2");
    step(13'h075F, 8'h00, 1'b1, "R6");
    step(13'h1000, 8'h00, 1'b1, "R6");
    step(13'h1BFF, 8'h00, 1'b1, "R4");
    step(13'h1C00, 8'h00, 1'b1, "R6");
    step(13'h1000, 8'h00, 1'b1, "R3");
    step(13'h0085, 8'hE0, 1'b1, "R8");
    step(13'h1100, 8'h00, 1'b1, "R8");
    step(13'h0F2F, 8'h00, 1'b1, "R5");
    step(13'h0090, 8'hC0, 1'b1, "R7");
    step(13'h1200, 8'h00, 1'b1, "R7");
    step(13'h0800, 8'h00, 1'b1, "R4");
    step(13'h1FFF, 8'h00, 1'b1, "R3");
    step(13'h1200, 8'h00, 1'b1, "R3");
    step(13'h00BF, 8'h20, 1'b1, "R7");
    step(13'h1300, 8'h00, 1'b1, "R7");
    step(13'h00C0, 8'hE0, 1'b1, "R7");
    step(13'h1300, 8'h00, 1'b1, "R7");
    step(13'h0FFF, 8'h00, 1'b0, "R9");
    step(13'h077F, 8'h00, 1'b0, "R9");
    step(13'h0080, 8'hE0, 1'b0, "R9");
    step(13'h1300, 8'h00, 1'b0, "R9");
    step(13'h1C00, 8'h00, 1'b1, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [12:0] a;
      logic [7:0] d;
      a = 13'($urandom);
      d = 8'($urandom);
      case ($urandom % 6)
        0: a = {3'b011, a[9:4], 1'b1, a[2:0]};
        1: a = {3'b001, a[9:4], 1'b1, a[2:0]};
        2: a = {7'b0000010, a[5:0]};
        3: a = {3'b111, a[9:0]};
        default: a = {1'b1, a[11:0]};
      endcase
      step(a, d, 1'($urandom % 8 != 0), "R2");
    end
    finish_run();
  end
endmodule